// File: doc/BRIEF.md
# Store-Load Ordering Violation Detector

When a store resolves its address, this block checks whether a load that is younger than the store has already read memory that the store writes. If one has, the block asks for a rollback to that load, so that the load and everything after it run again with the correct data. Loads come from three places:

- the load queue, for loads that already completed or are waiting on a cache miss;
- the writeback stage, for loads finishing in the same cycle as the store;
- an earlier pipeline stage, for loads that have computed their address but not yet finished.

Every source is searched oldest-first. The block picks the oldest violator over the three sources and then over all store ports. It drops the request when the redirect presented in the store's cycle already flushes that load.

The search takes two cycles. Cycle 0 does all the address and mask matching and registers the results. Cycle 1 selects the oldest candidate and filters it against the redirect. The result is then registered, so a rollback appears on the outputs two clock edges after the store is presented.

Age tags are circular pointers: one wrap bit above an `AGE_W`-bit value. The queue must keep its entry data stable through cycle 1, because the selected entry's tag and PC are read then.

Top module: `mem_order_guard`

## Requirements
- R1: A load conflicts with a store only when the address bits above the byte-offset field are equal (the same `BYTES`-byte word) and the two byte masks share at least one set bit.
- R2: A writeback-stage or early-stage load is a violator only if it is strictly younger than the store. Tag `a` is younger than tag `b` when (wrap(a) XOR wrap(b)) XOR (value(a) > value(b)), with the wrap bit being the tag's top bit.
- R3: Queue entries are searched only from the store's queue slot up to, but not including, the queue tail. If the wrap bits of the slot and the tail are equal, the window is [slot, tail). If they differ, the window runs from the slot to the end of the queue and then from entry 0 up to the tail.
- R4: A queue entry is searched only when it is allocated and either holds data or is waiting on a miss.
- R5: Among matching queue entries, the first one met going upward from the store's slot, wrapping past the last entry, is selected.
- R6: When both slots of a pipeline source violate, the older slot (by the R2 rule) is selected; a single violating slot is selected directly.
- R7: Among the queue, writeback and early-stage candidates of one store port, the oldest valid one is selected, an invalid candidate counting as younger than any valid one.
- R8: The results of the store ports are reduced by the same oldest-valid rule.
- R9: The rollback is dropped when the redirect presented with the store was valid and the selected load is strictly younger than the redirect's tag. An equal tag is not dropped.
- R10: The rollback is dropped when the redirect presented with the store was valid and unconditional.
- R11: A rollback is raised only when the triggering store was valid. It appears on `rb_valid`, `rb_tag` and `rb_pc` after the second rising edge following the store.
- R12: During and straight after reset `rb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | N_ST | Store valid per port |
| st_addr | input | N_ST x ADDR_W | Store physical address |
| st_mask | input | N_ST x BYTES | Store byte mask |
| st_tag | input | N_ST x (AGE_W+1) | Store age tag |
| st_slot_wrap | input | N_ST | Wrap bit of the store's queue slot |
| st_slot | input | N_ST x log2(Q_DEPTH) | Queue slot of the store |
| q_tail_wrap | input | 1 | Wrap bit of the queue tail |
| q_tail | input | log2(Q_DEPTH) | Queue tail index |
| q_alloc | input | Q_DEPTH | Entry allocated |
| q_has_data | input | Q_DEPTH | Entry holds load data |
| q_miss | input | Q_DEPTH | Entry waits on a cache miss |
| q_addr | input | Q_DEPTH x ADDR_W | Entry load address |
| q_mask | input | Q_DEPTH x BYTES | Entry load byte mask |
| q_tag | input | Q_DEPTH x (AGE_W+1) | Entry age tag |
| q_pc | input | Q_DEPTH x PC_W | Entry PC |
| wb_valid | input | 2 | Writeback-stage load valid per slot |
| wb_addr | input | 2 x ADDR_W | Writeback-stage load address |
| wb_mask | input | 2 x BYTES | Writeback-stage load byte mask |
| wb_tag | input | 2 x (AGE_W+1) | Writeback-stage load age tag |
| wb_pc | input | 2 x PC_W | Writeback-stage load PC |
| ea_valid | input | 2 | Early-stage load valid per slot |
| ea_addr | input | 2 x ADDR_W | Early-stage load address |
| ea_mask | input | 2 x BYTES | Early-stage load byte mask |
| ea_tag | input | 2 x (AGE_W+1) | Early-stage load age tag |
| ea_pc | input | 2 x PC_W | Early-stage load PC |
| redir_valid | input | 1 | Redirect valid |
| redir_uncond | input | 1 | Redirect is unconditional |
| redir_tag | input | AGE_W+1 | Redirect age tag |
| rb_valid | output | 1 | Rollback request valid |
| rb_tag | output | AGE_W+1 | Age tag of the load to roll back to |
| rb_pc | output | PC_W | PC of the load to roll back to |

## Verification
The bench builds the block with `Q_DEPTH`=8, `AGE_W`=4, `ADDR_W`=12, `BYTES`=8 and two store ports. A 4-bit age value makes tags wrap within a few steps, so random tag spreads straddle the wrap bit all the time. A 12-bit address drawn from only four words makes random conflicts frequent. An 8-entry queue lets the random store slot and tail cover empty, full and wrapped search windows.

// File: rtl/svd_pkg.sv
package svd_pkg;

  // load slots per pipeline source
  localparam int unsigned SVD_SLOTS = 2;

  // circular age compare: a strictly younger than b; flag at bit vw
  function automatic logic tag_younger(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned vw);
    logic [31:0] vm;
    vm = (32'd1 << vw[4:0]) - 32'd1;
    return (a[vw[4:0]] ^ b[vw[4:0]]) ^ ((a & vm) > (b & vm));
  endfunction

endpackage

// File: rtl/svd_slot_pair.sv
module svd_slot_pair
  import svd_pkg::*;
#(
  parameter int unsigned AGE_W  = 6,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTES  = 8,
  parameter int unsigned PC_W   = 16,
  localparam int unsigned TAG_W = AGE_W + 1,
  localparam int unsigned WLSB  = $clog2(BYTES)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_W-1:0]                   st_addr,
  input  logic [BYTES-1:0]                    st_mask,
  input  logic [TAG_W-1:0]                    st_tag,
  input  logic [SVD_SLOTS-1:0]                ld_valid,
  input  logic [SVD_SLOTS-1:0][ADDR_W-1:0]    ld_addr,
  input  logic [SVD_SLOTS-1:0][BYTES-1:0]     ld_mask,
  input  logic [SVD_SLOTS-1:0][TAG_W-1:0]     ld_tag,
  input  logic [SVD_SLOTS-1:0][PC_W-1:0]      ld_pc,
  output logic                                sel_valid,
  output logic [TAG_W-1:0]                    sel_tag,
  output logic [PC_W-1:0]                     sel_pc
);

  logic [SVD_SLOTS-1:0]             hit_d, hit_q;
  logic [SVD_SLOTS-1:0][TAG_W-1:0]  tag_q;
  logic [SVD_SLOTS-1:0][PC_W-1:0]   pc_q;

  // cycle 0: younger, same word, overlapping bytes
  for (genvar s = 0; s < SVD_SLOTS; s++) begin : g_slot
    assign hit_d[s] = ld_valid[s]
                    && tag_younger(32'(ld_tag[s]), 32'(st_tag), AGE_W)
                    && ((ld_addr[s] >> WLSB) == (st_addr >> WLSB))
                    && (|(ld_mask[s] & st_mask));
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= hit_d;
  end

  always_ff @(posedge clk) begin
    tag_q <= ld_tag;
    pc_q  <= ld_pc;
  end

  // cycle 1: oldest of the two slots
  logic pick;
  always_comb begin
    if (hit_q == 2'b11)
      pick = tag_younger(32'(tag_q[0]), 32'(tag_q[1]), AGE_W);
    else
      pick = !hit_q[0];
  end

  assign sel_valid = |hit_q;
  assign sel_tag   = tag_q[pick];
  assign sel_pc    = pc_q[pick];

  // R6
  oldest_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_q == 2'b11) |-> (!tag_younger(32'(sel_tag), 32'(tag_q[0]), AGE_W)
                      && !tag_younger(32'(sel_tag), 32'(tag_q[1]), AGE_W)));

endmodule

// File: rtl/svd_port.sv
module svd_port
  import svd_pkg::*;
#(
  parameter int unsigned Q_DEPTH = 16,
  parameter int unsigned AGE_W   = 6,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTES   = 8,
  parameter int unsigned PC_W    = 16,
  localparam int unsigned QIW    = $clog2(Q_DEPTH),
  localparam int unsigned TAG_W  = AGE_W + 1,
  localparam int unsigned WLSB   = $clog2(BYTES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              st_valid,
  input  logic [ADDR_W-1:0]                 st_addr,
  input  logic [BYTES-1:0]                  st_mask,
  input  logic [TAG_W-1:0]                  st_tag,
  input  logic                              st_slot_wrap,
  input  logic [QIW-1:0]                    st_slot,
  input  logic                              q_tail_wrap,
  input  logic [QIW-1:0]                    q_tail,
  input  logic [Q_DEPTH-1:0]                q_alloc,
  input  logic [Q_DEPTH-1:0]                q_has_data,
  input  logic [Q_DEPTH-1:0]                q_miss,
  input  logic [Q_DEPTH-1:0][ADDR_W-1:0]    q_addr,
  input  logic [Q_DEPTH-1:0][BYTES-1:0]     q_mask,
  input  logic [Q_DEPTH-1:0][TAG_W-1:0]     q_tag,
  input  logic [Q_DEPTH-1:0][PC_W-1:0]      q_pc,
  input  logic [SVD_SLOTS-1:0]              wb_valid,
  input  logic [SVD_SLOTS-1:0][ADDR_W-1:0]  wb_addr,
  input  logic [SVD_SLOTS-1:0][BYTES-1:0]   wb_mask,
  input  logic [SVD_SLOTS-1:0][TAG_W-1:0]   wb_tag,
  input  logic [SVD_SLOTS-1:0][PC_W-1:0]    wb_pc,
  input  logic [SVD_SLOTS-1:0]              ea_valid,
  input  logic [SVD_SLOTS-1:0][ADDR_W-1:0]  ea_addr,
  input  logic [SVD_SLOTS-1:0][BYTES-1:0]   ea_mask,
  input  logic [SVD_SLOTS-1:0][TAG_W-1:0]   ea_tag,
  input  logic [SVD_SLOTS-1:0][PC_W-1:0]    ea_pc,
  output logic                              p_valid,
  output logic [TAG_W-1:0]                  p_tag,
  output logic [PC_W-1:0]                   p_pc
);

  // ---------------- cycle 0: queue window and match ----------------
  logic [Q_DEPTH-1:0] start_pm, tail_pm, window, qhit_d;
  logic [Q_DEPTH-1:0] qhit_q, start_q;
  logic               stv_q;

  for (genvar j = 0; j < Q_DEPTH; j++) begin : g_ent
    assign start_pm[j] = (QIW'(j) < st_slot);
    assign tail_pm[j]  = (QIW'(j) < q_tail);
    assign qhit_d[j]   = window[j] && q_alloc[j] && (q_has_data[j] || q_miss[j])
                       && ((q_addr[j] >> WLSB) == (st_addr >> WLSB))
                       && (|(q_mask[j] & st_mask));

    // R4
    q_eligible_chk: assert property (@(posedge clk) disable iff (rst)
      qhit_q[j] |-> $past(q_alloc[j] && (q_has_data[j] || q_miss[j])));
  end

  assign window = (st_slot_wrap == q_tail_wrap) ? (start_pm ^ tail_pm)
                                                : ~(start_pm ^ tail_pm);

  always_ff @(posedge clk) begin
    if (rst) begin
      qhit_q <= '0;
      stv_q  <= 1'b0;
    end else begin
      qhit_q <= qhit_d;
      stv_q  <= st_valid;
    end
  end

  always_ff @(posedge clk) start_q <= start_pm;

  // ---------------- pipeline sources ----------------
  logic             wb_v, ea_v;
  logic [TAG_W-1:0] wb_t, ea_t;
  logic [PC_W-1:0]  wb_p, ea_p;

  svd_slot_pair #(.AGE_W(AGE_W), .ADDR_W(ADDR_W), .BYTES(BYTES), .PC_W(PC_W)) i_wb (
    .clk(clk), .rst(rst), .st_addr(st_addr), .st_mask(st_mask), .st_tag(st_tag),
    .ld_valid(wb_valid), .ld_addr(wb_addr), .ld_mask(wb_mask), .ld_tag(wb_tag),
    .ld_pc(wb_pc), .sel_valid(wb_v), .sel_tag(wb_t), .sel_pc(wb_p));

  svd_slot_pair #(.AGE_W(AGE_W), .ADDR_W(ADDR_W), .BYTES(BYTES), .PC_W(PC_W)) i_ea (
    .clk(clk), .rst(rst), .st_addr(st_addr), .st_mask(st_mask), .st_tag(st_tag),
    .ld_valid(ea_valid), .ld_addr(ea_addr), .ld_mask(ea_mask), .ld_tag(ea_tag),
    .ld_pc(ea_pc), .sel_valid(ea_v), .sel_tag(ea_t), .sel_pc(ea_p));

  // ---------------- cycle 1: oldest queue entry ----------------
  logic [Q_DEPTH-1:0] upper;
  logic [QIW-1:0]     qpick;
  logic               q_v;
  logic [TAG_W-1:0]   q_t;
  logic [PC_W-1:0]    q_p;

  assign upper = qhit_q & ~start_q;

  always_comb begin
    qpick = '0;
    for (int j = Q_DEPTH - 1; j >= 0; j--) begin
      if (|upper) begin
        if (upper[j]) qpick = QIW'(j);
      end else begin
        if (qhit_q[j]) qpick = QIW'(j);
      end
    end
  end

  assign q_v = |qhit_q;
  assign q_t = q_tag[qpick];
  assign q_p = q_pc[qpick];

  // ---------------- cycle 1: oldest of three sources ----------------
  logic m10, m20, m21;
  assign m10 = (q_v && wb_v) ? tag_younger(32'(wb_t), 32'(q_t), AGE_W) : !wb_v;
  assign m20 = (q_v && ea_v) ? tag_younger(32'(ea_t), 32'(q_t), AGE_W) : !ea_v;
  assign m21 = (wb_v && ea_v) ? tag_younger(32'(ea_t), 32'(wb_t), AGE_W) : !ea_v;

  always_comb begin
    if (m10 && m20) begin
      p_tag = q_t;
      p_pc  = q_p;
    end else if (!m10 && m21) begin
      p_tag = wb_t;
      p_pc  = wb_p;
    end else begin
      p_tag = ea_t;
      p_pc  = ea_p;
    end
  end

  assign p_valid = stv_q && (q_v || wb_v || ea_v);

  // R7
  oldest_src_chk: assert property (@(posedge clk) disable iff (rst)
    (p_valid && q_v && wb_v && ea_v) |->
      (!tag_younger(32'(p_tag), 32'(q_t), AGE_W)
       && !tag_younger(32'(p_tag), 32'(wb_t), AGE_W)
       && !tag_younger(32'(p_tag), 32'(ea_t), AGE_W)));

endmodule

// File: rtl/mem_order_guard.sv
module mem_order_guard
  import svd_pkg::*;
#(
  parameter int unsigned N_ST    = 2,
  parameter int unsigned Q_DEPTH = 16,
  parameter int unsigned AGE_W   = 6,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTES   = 8,
  parameter int unsigned PC_W    = 16,
  localparam int unsigned QIW    = $clog2(Q_DEPTH),
  localparam int unsigned TAG_W  = AGE_W + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_ST-1:0]                   st_valid,
  input  logic [N_ST-1:0][ADDR_W-1:0]       st_addr,
  input  logic [N_ST-1:0][BYTES-1:0]        st_mask,
  input  logic [N_ST-1:0][TAG_W-1:0]        st_tag,
  input  logic [N_ST-1:0]                   st_slot_wrap,
  input  logic [N_ST-1:0][QIW-1:0]          st_slot,
  input  logic                              q_tail_wrap,
  input  logic [QIW-1:0]                    q_tail,
  input  logic [Q_DEPTH-1:0]                q_alloc,
  input  logic [Q_DEPTH-1:0]                q_has_data,
  input  logic [Q_DEPTH-1:0]                q_miss,
  input  logic [Q_DEPTH-1:0][ADDR_W-1:0]    q_addr,
  input  logic [Q_DEPTH-1:0][BYTES-1:0]     q_mask,
  input  logic [Q_DEPTH-1:0][TAG_W-1:0]     q_tag,
  input  logic [Q_DEPTH-1:0][PC_W-1:0]      q_pc,
  input  logic [SVD_SLOTS-1:0]              wb_valid,
  input  logic [SVD_SLOTS-1:0][ADDR_W-1:0]  wb_addr,
  input  logic [SVD_SLOTS-1:0][BYTES-1:0]   wb_mask,
  input  logic [SVD_SLOTS-1:0][TAG_W-1:0]   wb_tag,
  input  logic [SVD_SLOTS-1:0][PC_W-1:0]    wb_pc,
  input  logic [SVD_SLOTS-1:0]              ea_valid,
  input  logic [SVD_SLOTS-1:0][ADDR_W-1:0]  ea_addr,
  input  logic [SVD_SLOTS-1:0][BYTES-1:0]   ea_mask,
  input  logic [SVD_SLOTS-1:0][TAG_W-1:0]   ea_tag,
  input  logic [SVD_SLOTS-1:0][PC_W-1:0]    ea_pc,
  input  logic                              redir_valid,
  input  logic                              redir_uncond,
  input  logic [TAG_W-1:0]                  redir_tag,
  output logic                              rb_valid,
  output logic [TAG_W-1:0]                  rb_tag,
  output logic [PC_W-1:0]                   rb_pc
);

  logic [N_ST-1:0]             pv;
  logic [N_ST-1:0][TAG_W-1:0]  pt;
  logic [N_ST-1:0][PC_W-1:0]   pp;

  for (genvar p = 0; p < N_ST; p++) begin : g_port
    svd_port #(.Q_DEPTH(Q_DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W), .BYTES(BYTES),
               .PC_W(PC_W)) i_port (
      .clk(clk), .rst(rst),
      .st_valid(st_valid[p]), .st_addr(st_addr[p]), .st_mask(st_mask[p]),
      .st_tag(st_tag[p]), .st_slot_wrap(st_slot_wrap[p]), .st_slot(st_slot[p]),
      .q_tail_wrap(q_tail_wrap), .q_tail(q_tail),
      .q_alloc(q_alloc), .q_has_data(q_has_data), .q_miss(q_miss),
      .q_addr(q_addr), .q_mask(q_mask), .q_tag(q_tag), .q_pc(q_pc),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_mask(wb_mask), .wb_tag(wb_tag),
      .wb_pc(wb_pc),
      .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_mask(ea_mask), .ea_tag(ea_tag),
      .ea_pc(ea_pc),
      .p_valid(pv[p]), .p_tag(pt[p]), .p_pc(pp[p]));
  end

  // fold store ports, oldest valid wins
  logic             sel_v;
  logic [TAG_W-1:0] sel_t;
  logic [PC_W-1:0]  sel_p;

  always_comb begin
    sel_v = pv[0];
    sel_t = pt[0];
    sel_p = pp[0];
    for (int p = 1; p < N_ST; p++) begin
      if (pv[p] && (!sel_v || tag_younger(32'(sel_t), 32'(pt[p]), AGE_W))) begin
        sel_v = 1'b1;
        sel_t = pt[p];
        sel_p = pp[p];
      end
    end
  end

  // redirect seen alongside the store
  logic             rd_v_q, rd_u_q;
  logic [TAG_W-1:0] rd_t_q;

  always_ff @(posedge clk) begin
    if (rst) rd_v_q <= 1'b0;
    else     rd_v_q <= redir_valid;
  end

  always_ff @(posedge clk) begin
    rd_u_q <= redir_uncond;
    rd_t_q <= redir_tag;
  end

  logic keep;
  assign keep = sel_v
             && !(rd_v_q && tag_younger(32'(sel_t), 32'(rd_t_q), AGE_W))
             && !(rd_v_q && rd_u_q);

  always_ff @(posedge clk) begin
    if (rst) rb_valid <= 1'b0;
    else     rb_valid <= keep;
  end

  always_ff @(posedge clk) begin
    rb_tag <= sel_t;
    rb_pc  <= sel_p;
  end

  // R11
  rb_needs_store_chk: assert property (@(posedge clk) disable iff (rst)
    rb_valid |-> $past(|st_valid, 2));

  // R10
  uncond_kill_chk: assert property (@(posedge clk) disable iff (rst)
    $past(redir_valid && redir_uncond, 2) |-> !rb_valid);

  // R9
  redir_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (rb_valid && $past(redir_valid, 2)) |->
      !tag_younger(32'(rb_tag), 32'($past(redir_tag, 2)), AGE_W));

endmodule

// File: tb/test_mem_order_guard.sv
module test_mem_order_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NST = 2;
  localparam int QD  = 8;
  localparam int QIW = 3;
  localparam int AGW = 4;
  localparam int TW  = AGW + 1;
  localparam int ADR = 12;
  localparam int MW  = 8;
  localparam int PCW = 16;

  typedef struct packed {
    logic          v;
    logic [TW-1:0] tag;
    logic [PCW-1:0] pc;
  } cand_t;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic [NST-1:0]             st_valid;
  logic [NST-1:0][ADR-1:0]    st_addr;
  logic [NST-1:0][MW-1:0]     st_mask;
  logic [NST-1:0][TW-1:0]     st_tag;
  logic [NST-1:0]             st_slot_wrap;
  logic [NST-1:0][QIW-1:0]    st_slot;
  logic                       q_tail_wrap;
  logic [QIW-1:0]             q_tail;
  logic [QD-1:0]              q_alloc, q_has_data, q_miss;
  logic [QD-1:0][ADR-1:0]     q_addr;
  logic [QD-1:0][MW-1:0]      q_mask;
  logic [QD-1:0][TW-1:0]      q_tag;
  logic [QD-1:0][PCW-1:0]     q_pc;
  logic [1:0]                 wb_valid, ea_valid;
  logic [1:0][ADR-1:0]        wb_addr, ea_addr;
  logic [1:0][MW-1:0]         wb_mask, ea_mask;
  logic [1:0][TW-1:0]         wb_tag, ea_tag;
  logic [1:0][PCW-1:0]        wb_pc, ea_pc;
  logic                       redir_valid, redir_uncond;
  logic [TW-1:0]              redir_tag;
  logic                       rb_valid;
  logic [TW-1:0]              rb_tag;
  logic [PCW-1:0]             rb_pc;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  mem_order_guard #(.N_ST(NST), .Q_DEPTH(QD), .AGE_W(AGW), .ADDR_W(ADR),
                    .BYTES(MW), .PC_W(PCW)) i_mem_order_guard (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_addr(st_addr), .st_mask(st_mask), .st_tag(st_tag),
    .st_slot_wrap(st_slot_wrap), .st_slot(st_slot),
    .q_tail_wrap(q_tail_wrap), .q_tail(q_tail),
    .q_alloc(q_alloc), .q_has_data(q_has_data), .q_miss(q_miss),
    .q_addr(q_addr), .q_mask(q_mask), .q_tag(q_tag), .q_pc(q_pc),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_mask(wb_mask), .wb_tag(wb_tag),
    .wb_pc(wb_pc),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_mask(ea_mask), .ea_tag(ea_tag),
    .ea_pc(ea_pc),
    .redir_valid(redir_valid), .redir_uncond(redir_uncond), .redir_tag(redir_tag),
    .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_pc(rb_pc));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  function automatic logic yng(logic [TW-1:0] a, logic [TW-1:0] b);
    return (a[TW-1] ^ b[TW-1]) ^ (a[TW-2:0] > b[TW-2:0]);
  endfunction

  function automatic logic confl(logic [ADR-1:0] a, logic [MW-1:0] ma,
                                 logic [ADR-1:0] b, logic [MW-1:0] mb);
    return (a[ADR-1:3] == b[ADR-1:3]) && (|(ma & mb));
  endfunction

  function automatic cand_t older_of(cand_t a, cand_t b);
    if (!a.v) return b;
    if (!b.v) return a;
    return yng(a.tag, b.tag) ? b : a;
  endfunction

  function automatic cand_t mk(logic v, logic [TW-1:0] t, logic [PCW-1:0] p);
    cand_t c;
    c.v = v; c.tag = t; c.pc = p;
    return c;
  endfunction

  function automatic cand_t mdl_port(int p);
    cand_t q, w, e;
    int len, idx;
    q = '0;
    if (st_slot_wrap[p] == q_tail_wrap) len = int'(q_tail) - int'(st_slot[p]);
    else                                len = QD - int'(st_slot[p]) + int'(q_tail);
    for (int k = 0; k < len; k++) begin
      idx = (int'(st_slot[p]) + k) % QD;
      if (!q.v && q_alloc[idx] && (q_has_data[idx] || q_miss[idx])
          && confl(q_addr[idx], q_mask[idx], st_addr[p], st_mask[p]))
        q = mk(1'b1, q_tag[idx], q_pc[idx]);
    end
    w = '0;
    e = '0;
    for (int s = 0; s < 2; s++) begin
      if (wb_valid[s] && yng(wb_tag[s], st_tag[p])
          && confl(wb_addr[s], wb_mask[s], st_addr[p], st_mask[p]))
        w = older_of(w, mk(1'b1, wb_tag[s], wb_pc[s]));
      if (ea_valid[s] && yng(ea_tag[s], st_tag[p])
          && confl(ea_addr[s], ea_mask[s], st_addr[p], st_mask[p]))
        e = older_of(e, mk(1'b1, ea_tag[s], ea_pc[s]));
    end
    if (!st_valid[p]) return '0;
    return older_of(older_of(q, w), e);
  endfunction

  function automatic cand_t mdl_all();
    cand_t r;
    r = '0;
    for (int p = 0; p < NST; p++) r = older_of(r, mdl_port(p));
    if (r.v && redir_valid && (redir_uncond || yng(r.tag, redir_tag))) r = '0;
    return r;
  endfunction

  // ---------------- stimulus helpers ----------------
  task automatic clear_all();
    st_valid = '0; st_addr = '0; st_mask = '0; st_tag = '0;
    st_slot_wrap = '0; st_slot = '0;
    q_tail_wrap = 1'b0; q_tail = '0;
    q_alloc = '0; q_has_data = '0; q_miss = '0;
    q_addr = '0; q_mask = '0; q_tag = '0; q_pc = '0;
    wb_valid = '0; wb_addr = '0; wb_mask = '0; wb_tag = '0; wb_pc = '0;
    ea_valid = '0; ea_addr = '0; ea_mask = '0; ea_tag = '0; ea_pc = '0;
    redir_valid = 1'b0; redir_uncond = 1'b0; redir_tag = '0;
  endtask

  // port 0 store: word 8, low nibble, tag 10; window [2,5)
  task automatic base_store();
    clear_all();
    st_valid[0] = 1'b1; st_addr[0] = 12'h040; st_mask[0] = 8'h0F; st_tag[0] = 5'd10;
    st_slot[0] = 3'd2; st_slot_wrap[0] = 1'b0; q_tail = 3'd5; q_tail_wrap = 1'b0;
  endtask

  task automatic put_q(int i, logic a, logic d, logic m, logic [ADR-1:0] ad,
                       logic [MW-1:0] mk_, logic [TW-1:0] t, logic [PCW-1:0] pc);
    q_alloc[i] = a; q_has_data[i] = d; q_miss[i] = m;
    q_addr[i] = ad; q_mask[i] = mk_; q_tag[i] = t; q_pc[i] = pc;
  endtask

  // inputs are set at a negedge; apply, hold queue, check after second edge
  task automatic run_vec(string what);
    cand_t ex;
    ex = mdl_all();
    @(posedge clk);
    @(negedge clk);
    st_valid = '0;
    redir_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (rb_valid !== ex.v || (ex.v && (rb_tag !== ex.tag || rb_pc !== ex.pc))) begin
      n_fails++;
      $display("FAIL %s: got valid=%0d tag=%0h pc=%0h, expected valid=%0d tag=%0h pc=%0h",
               what, rb_valid, rb_tag, rb_pc, ex.v, ex.tag, ex.pc);
    end
  endtask

  task automatic rand_vec();
    int pool[13];
    int base, tmp, j;
    clear_all();
    for (int k = 0; k < 13; k++) pool[k] = (k < 3) ? (k - 3) : (k - 2);
    for (int k = 12; k > 0; k--) begin
      j = int'($urandom % (k + 1));
      tmp = pool[k]; pool[k] = pool[j]; pool[j] = tmp;
    end
    base = int'($urandom % 32);
    for (int p = 0; p < NST; p++) begin
      st_valid[p]     = ($urandom % 8) != 0;
      st_addr[p]      = ADR'((($urandom % 4) << 3) | ($urandom % 8));
      st_mask[p]      = MW'($urandom);
      st_tag[p]       = TW'(base + int'($urandom % 3) - 1);
      st_slot[p]      = QIW'($urandom);
      st_slot_wrap[p] = 1'($urandom);
    end
    q_tail      = QIW'($urandom);
    q_tail_wrap = 1'($urandom);
    for (int p = 0; p < NST; p++) begin
      if (st_slot_wrap[p] == q_tail_wrap && st_slot[p] > q_tail) st_slot[p] = q_tail;
      if (st_slot_wrap[p] != q_tail_wrap && st_slot[p] < q_tail) st_slot[p] = q_tail;
    end
    for (int i = 0; i < QD; i++)
      put_q(i, 1'($urandom), 1'($urandom), 1'($urandom),
            ADR'((($urandom % 4) << 3) | ($urandom % 8)), MW'($urandom & $urandom),
            TW'(base + pool[i]), PCW'($urandom));
    for (int s = 0; s < 2; s++) begin
      wb_valid[s] = 1'($urandom); ea_valid[s] = 1'($urandom);
      wb_addr[s]  = ADR'((($urandom % 4) << 3) | ($urandom % 8));
      ea_addr[s]  = ADR'((($urandom % 4) << 3) | ($urandom % 8));
      wb_mask[s]  = MW'($urandom); ea_mask[s] = MW'($urandom);
      wb_tag[s]   = TW'(base + pool[8 + s]); ea_tag[s] = TW'(base + pool[10 + s]);
      wb_pc[s]    = PCW'($urandom); ea_pc[s] = PCW'($urandom);
    end
    redir_valid  = ($urandom % 5) == 0;
    redir_uncond = ($urandom % 3) == 0;
    redir_tag    = TW'(base + int'($urandom % 13) - 4);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int seed;
    seed = int'($urandom(32'd2024));
    clear_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: output low while in reset
    n_checks++;
    if (rb_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R12 in reset: got %0d expected 0", rb_valid);
    end
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (rb_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R12 after reset: got %0d expected 0", rb_valid);
    end

    // R1: same word, overlapping bytes
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h044; wb_mask[0] = 8'h18;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'h1111;
    run_vec("R1 overlap");
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h044; wb_mask[0] = 8'hF0;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'h1111;
    run_vec("R1 disjoint bytes");
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h048; wb_mask[0] = 8'h0F;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'h1111;
    run_vec("R1 other word");

    // R2: age rule, including wrap bit
    base_store(); ea_valid[1] = 1; ea_addr[1] = 12'h040; ea_mask[1] = 8'h01;
    ea_tag[1] = 5'd9; ea_pc[1] = 16'h2222;
    run_vec("R2 older load");
    base_store(); st_tag[0] = 5'd14; ea_valid[1] = 1; ea_addr[1] = 12'h040;
    ea_mask[1] = 8'h01; ea_tag[1] = 5'd17; ea_pc[1] = 16'h2223;
    run_vec("R2 wrapped younger");
    base_store(); st_tag[0] = 5'd17; ea_valid[1] = 1; ea_addr[1] = 12'h040;
    ea_mask[1] = 8'h01; ea_tag[1] = 5'd14; ea_pc[1] = 16'h2224;
    run_vec("R2 wrapped older");

    // R3: queue window
    base_store(); put_q(6, 1, 1, 0, 12'h041, 8'h02, 5'd13, 16'h3006);
    run_vec("R3 outside window");
    base_store(); put_q(3, 1, 1, 0, 12'h041, 8'h02, 5'd13, 16'h3003);
    run_vec("R3 inside window");
    base_store(); st_slot[0] = 3'd6; q_tail = 3'd2; q_tail_wrap = 1'b1;
    put_q(1, 1, 1, 0, 12'h041, 8'h02, 5'd13, 16'h3001);
    run_vec("R3 wrapped window hit");
    base_store(); st_slot[0] = 3'd6; q_tail = 3'd2; q_tail_wrap = 1'b1;
    put_q(4, 1, 1, 0, 12'h041, 8'h02, 5'd13, 16'h3004);
    run_vec("R3 wrapped window gap");
    base_store(); st_slot[0] = 3'd4; q_tail = 3'd4; q_tail_wrap = 1'b1;
    put_q(2, 1, 1, 0, 12'h041, 8'h02, 5'd13, 16'h3012);
    run_vec("R3 full queue");

    // R4: eligibility
    base_store(); put_q(3, 1, 0, 0, 12'h041, 8'h02, 5'd13, 16'h4003);
    run_vec("R4 no data no miss");
    base_store(); put_q(3, 1, 0, 1, 12'h041, 8'h02, 5'd13, 16'h4013);
    run_vec("R4 miss pending");
    base_store(); put_q(3, 0, 1, 0, 12'h041, 8'h02, 5'd13, 16'h4023);
    run_vec("R4 not allocated");

    // R5: oldest queue entry from the slot upward
    base_store(); st_slot[0] = 3'd6; q_tail = 3'd3; q_tail_wrap = 1'b1;
    put_q(1, 1, 1, 0, 12'h041, 8'h02, 5'd15, 16'h5001);
    put_q(7, 1, 1, 0, 12'h041, 8'h02, 5'd12, 16'h5007);
    run_vec("R5 wrap order");

    // R6: two slots
    base_store(); wb_valid = 2'b11; wb_addr[0] = 12'h040; wb_addr[1] = 12'h043;
    wb_mask[0] = 8'h01; wb_mask[1] = 8'h08; wb_tag[0] = 5'd14; wb_tag[1] = 5'd12;
    wb_pc[0] = 16'h6000; wb_pc[1] = 16'h6001;
    run_vec("R6 slot1 older");

    // R7: three sources, early stage oldest
    base_store(); put_q(3, 1, 1, 0, 12'h041, 8'h02, 5'd15, 16'h7003);
    wb_valid[0] = 1; wb_addr[0] = 12'h040; wb_mask[0] = 8'h01; wb_tag[0] = 5'd13;
    wb_pc[0] = 16'h7100;
    ea_valid[1] = 1; ea_addr[1] = 12'h040; ea_mask[1] = 8'h04; ea_tag[1] = 5'd11;
    ea_pc[1] = 16'h7201;
    run_vec("R7 early oldest");

    // R8: two store ports
    base_store(); put_q(3, 1, 1, 0, 12'h041, 8'h02, 5'd14, 16'h8003);
    st_valid[1] = 1; st_addr[1] = 12'h047; st_mask[1] = 8'h80; st_tag[1] = 5'd8;
    st_slot[1] = 3'd5; st_slot_wrap[1] = 1'b0;
    wb_valid[1] = 1; wb_addr[1] = 12'h040; wb_mask[1] = 8'h81; wb_tag[1] = 5'd9;
    wb_pc[1] = 16'h8101;
    run_vec("R8 port1 older");

    // R9: redirect tag filter
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h040; wb_mask[0] = 8'h01;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'h9000; redir_valid = 1; redir_tag = 5'd11;
    run_vec("R9 covered by redirect");
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h040; wb_mask[0] = 8'h01;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'h9001; redir_valid = 1; redir_tag = 5'd12;
    run_vec("R9 equal tag kept");
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h040; wb_mask[0] = 8'h01;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'h9002; redir_valid = 1; redir_tag = 5'd13;
    run_vec("R9 younger redirect kept");

    // R10: unconditional redirect
    base_store(); wb_valid[0] = 1; wb_addr[0] = 12'h040; wb_mask[0] = 8'h01;
    wb_tag[0] = 5'd12; wb_pc[0] = 16'hA000; redir_valid = 1; redir_uncond = 1;
    redir_tag = 5'd20;
    run_vec("R10 unconditional");

    // R11: store not valid
    base_store(); st_valid[0] = 0; wb_valid[0] = 1; wb_addr[0] = 12'h040;
    wb_mask[0] = 8'h01; wb_tag[0] = 5'd12; wb_pc[0] = 16'hB000;
    run_vec("R11 no store");

    // random mix covering R1 to R11
    for (int n = 0; n < 400; n++) begin
      rand_vec();
      run_vec("R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule